// File: doc/BRIEF.md
# Hexadecimal Add/Subtract Calculator Controller

This block is the control core of a four-digit base-16 calculator. A keypad scanner delivers a one-cycle valid strobe with a 4-bit digit. A debounce stage delivers one-cycle pulses for add, subtract, equals and clear. The controller builds a first operand, called the accumulator, from the typed digits. An operator key stores the chosen operation and starts a second operand. Equals then writes the sum or difference back into the accumulator. A 16-bit value goes out to a separate display driver.

The controller has three states: accumulator entry, operand entry and result. In operand entry the display follows the operand as it is typed. In the other two states it shows the accumulator. The arithmetic has no overflow or sign handling. Results wrap modulo 2^16.

Top module: `radix16_calc_ctrl`

## Requirements
- R1: After reset is asserted, `disp_o` is 0x0000 and the block is in accumulator entry.
- R2: A digit strobe in accumulator entry shifts the accumulator left by 4 bits and puts `key_val_i` in bits [3:0]. The top digit is lost, so a fifth digit pushes out the oldest one.
- R3: An add pulse in accumulator entry stores the operation as addition and moves to operand entry. The operand starts at zero, so `disp_o` reads 0x0000 on the next cycle and then follows the operand's digits.
- R4: A subtract pulse in accumulator entry does the same, but stores the operation as subtraction.
- R5: An equals pulse in operand entry after an add stores accumulator + operand in the accumulator, moves to the result state and shows that value.
- R6: An equals pulse in operand entry after a subtract stores accumulator − operand, modulo 2^16 (for example 0x0001 − 0x0002 = 0xFFFF).
- R7: The sum wraps modulo 2^16, with no carry kept (for example 0xFFFF + 0x0002 = 0x0001).
- R8: A clear pulse in any state zeroes both operands and returns the block to accumulator entry, with `disp_o` = 0x0000.
- R9: Add and subtract pulses outside accumulator entry have no effect.
- R10: Equals pulses outside operand entry have no effect.
- R11: A digit strobe in the result state starts a new accumulator from zero holding just that digit, and returns to accumulator entry.
- R12: When inputs coincide in one cycle, the priority is: clear first, then an operator or equals pulse, then the digit strobe, which is dropped. Add beats subtract.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_vld_i | input | 1 | One-cycle digit strobe from the keypad scanner |
| key_val_i | input | 4 | Hex digit value |
| add_i | input | 1 | Add operator pulse |
| sub_i | input | 1 | Subtract operator pulse |
| eq_i | input | 1 | Equals pulse |
| clr_i | input | 1 | Clear pulse |
| disp_o | output | 16 | Value for the display driver |

## Verification
Every input effect appears on `disp_o` on the first cycle after the edge that samples it. A wrong state therefore shows one cycle after the next key. Typical symptoms are a digit landing in the wrong operand, a display that fails to clear after an operator, or a keypress that should be ignored changing the value. A wrong stored operator only shows at equals, as a sum where a difference was expected or the reverse. The stimulus therefore runs both operations back to back, with wrapping results. It also sends ignored keys in every state and reads the display right after each one.

// File: rtl/rcalc_pkg.sv
package rcalc_pkg;
  typedef enum logic [1:0] {
    ST_ACC  = 2'd0,
    ST_OPND = 2'd1,
    ST_RES  = 2'd2
  } calc_state_e;
endpackage

// File: rtl/rcalc_entry_reg.sv
module rcalc_entry_reg #(
  parameter int DIGITS = 4,
  parameter int NIB_W  = 4,
  localparam int DW    = DIGITS * NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wr_val_i,
  input  logic             seed_i,
  input  logic             shift_i,
  input  logic [NIB_W-1:0] key_i,
  output logic [DW-1:0]    q_o
);
  logic [DW-1:0] shifted;

  // lane 0 takes the key, each higher lane takes its lower neighbour
  for (genvar g = 0; g < DIGITS; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign shifted[NIB_W-1:0] = key_i;
    end else begin : g_up
      assign shifted[g*NIB_W +: NIB_W] = q_o[(g-1)*NIB_W +: NIB_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clr_i)   q_o <= '0;
    else if (wr_i)    q_o <= wr_val_i;
    else if (seed_i)  q_o <= {{(DW-NIB_W){1'b0}}, key_i};
    else if (shift_i) q_o <= shifted;
  end
endmodule

// File: rtl/rcalc_alu.sv
module rcalc_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          add_i,
  output logic [DW-1:0] y_o
);
  // both results formed, operator flag selects; carry/borrow dropped
  logic [DW-1:0] sum, diff;
  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  assign y_o  = add_i ? sum : diff;
endmodule

// File: rtl/radix16_calc_ctrl.sv
module radix16_calc_ctrl
  import rcalc_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int NIB_W  = 4,
  localparam int DW    = DIGITS * NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_vld_i,
  input  logic [NIB_W-1:0] key_val_i,
  input  logic             add_i,
  input  logic             sub_i,
  input  logic             eq_i,
  input  logic             clr_i,
  output logic [DW-1:0]    disp_o
);
  calc_state_e state_q, state_d;
  logic op_add_q;
  logic acc_clr, acc_wr, acc_seed, acc_shift;
  logic opn_clr, opn_shift;
  logic [DW-1:0] acc_q, opn_q, alu_y;

  always_comb begin
    state_d   = state_q;
    acc_clr   = 1'b0;
    acc_wr    = 1'b0;
    acc_seed  = 1'b0;
    acc_shift = 1'b0;
    opn_clr   = 1'b0;
    opn_shift = 1'b0;
    if (clr_i) begin
      state_d = ST_ACC;
      acc_clr = 1'b1;
      opn_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_ACC: begin
          if (add_i || sub_i) begin
            state_d = ST_OPND;
            opn_clr = 1'b1;
          end else if (key_vld_i) begin
            acc_shift = 1'b1;
          end
        end
        ST_OPND: begin
          if (eq_i) begin
            state_d = ST_RES;
            acc_wr  = 1'b1;
          end else if (key_vld_i) begin
            opn_shift = 1'b1;
          end
        end
        ST_RES: begin
          if (key_vld_i) begin
            state_d  = ST_ACC;
            acc_seed = 1'b1;
          end
        end
        default: state_d = ST_ACC;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ACC;
      op_add_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (!clr_i && state_q == ST_ACC && (add_i || sub_i))
        op_add_q <= add_i;  // add wins a tie
    end
  end

  rcalc_entry_reg #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_acc (
    .clk_i, .rst_ni,
    .clr_i(acc_clr), .wr_i(acc_wr), .wr_val_i(alu_y),
    .seed_i(acc_seed), .shift_i(acc_shift), .key_i(key_val_i),
    .q_o(acc_q)
  );

  rcalc_entry_reg #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_opn (
    .clk_i, .rst_ni,
    .clr_i(opn_clr), .wr_i(1'b0), .wr_val_i('0),
    .seed_i(1'b0), .shift_i(opn_shift), .key_i(key_val_i),
    .q_o(opn_q)
  );

  rcalc_alu #(.DW(DW)) u_alu (
    .a_i(acc_q), .b_i(opn_q), .add_i(op_add_q), .y_o(alu_y)
  );

  assign disp_o = (state_q == ST_OPND) ? opn_q : acc_q;

  // R8
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (disp_o == '0 && state_q == ST_ACC));

  // R2
  acc_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACC && key_vld_i && !add_i && !sub_i && !clr_i)
      |=> disp_o[NIB_W-1:0] == $past(key_val_i));

  // R3
  add_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACC && add_i && !clr_i)
      |=> (state_q == ST_OPND && disp_o == '0 && op_add_q));

  // R4
  sub_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACC && sub_i && !add_i && !clr_i)
      |=> (state_q == ST_OPND && disp_o == '0 && !op_add_q));

  // R5 R6
  eq_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPND && eq_i && !clr_i)
      |=> (state_q == ST_RES && disp_o == DW'($past(op_add_q) ?
            $past(acc_q) + $past(opn_q) : $past(acc_q) - $past(opn_q))));

  // R9
  op_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_ACC && (add_i || sub_i) && !eq_i && !key_vld_i && !clr_i)
      |=> $stable(disp_o));

  // R10
  eq_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_OPND && eq_i && !add_i && !sub_i && !key_vld_i && !clr_i)
      |=> $stable(disp_o));

  // R11
  fresh_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RES && key_vld_i && !clr_i)
      |=> (state_q == ST_ACC && disp_o == {{(DW-NIB_W){1'b0}}, $past(key_val_i)}));
endmodule

// File: tb/radix16_calc_ctrl_bench.sv
module radix16_calc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] K_KEY = 3'd0, K_ADD = 3'd1, K_SUB = 3'd2,
                         K_EQ  = 3'd3, K_CLR = 3'd4;
  localparam int NV = 32;
  // {kind, key, expected display, requirement number}
  localparam logic [26:0] VEC [NV] = '{
    {K_KEY, 4'h1, 16'h0001, 4'd2},  // R2
    {K_KEY, 4'h2, 16'h0012, 4'd2},
    {K_KEY, 4'h3, 16'h0123, 4'd2},
    {K_KEY, 4'h4, 16'h1234, 4'd2},
    {K_KEY, 4'h5, 16'h2345, 4'd2},  // oldest digit pushed out
    {K_EQ,  4'h0, 16'h2345, 4'd10}, // R10 equals in acc entry
    {K_ADD, 4'h0, 16'h0000, 4'd3},  // R3
    {K_KEY, 4'h1, 16'h0001, 4'd3},
    {K_KEY, 4'h0, 16'h0010, 4'd3},
    {K_ADD, 4'h0, 16'h0010, 4'd9},  // R9 add in operand entry
    {K_EQ,  4'h0, 16'h2355, 4'd5},  // R5
    {K_EQ,  4'h0, 16'h2355, 4'd10}, // equals in result
    {K_ADD, 4'h0, 16'h2355, 4'd9},
    {K_SUB, 4'h0, 16'h2355, 4'd9},
    {K_KEY, 4'hA, 16'h000A, 4'd11}, // R11
    {K_KEY, 4'hB, 16'h00AB, 4'd2},
    {K_SUB, 4'h0, 16'h0000, 4'd4},  // R4
    {K_KEY, 4'hF, 16'h000F, 4'd4},
    {K_EQ,  4'h0, 16'h009C, 4'd6},  // R6
    {K_CLR, 4'h0, 16'h0000, 4'd8},  // R8 from result
    {K_KEY, 4'h1, 16'h0001, 4'd2},
    {K_SUB, 4'h0, 16'h0000, 4'd4},
    {K_KEY, 4'h2, 16'h0002, 4'd4},
    {K_EQ,  4'h0, 16'hFFFF, 4'd6},  // negative wraps
    {K_KEY, 4'hF, 16'h000F, 4'd11},
    {K_KEY, 4'hF, 16'h00FF, 4'd2},
    {K_KEY, 4'hF, 16'h0FFF, 4'd2},
    {K_KEY, 4'hF, 16'hFFFF, 4'd2},
    {K_ADD, 4'h0, 16'h0000, 4'd3},
    {K_KEY, 4'h2, 16'h0002, 4'd3},
    {K_EQ,  4'h0, 16'h0001, 4'd7},  // R7 wrap on sum
    {K_CLR, 4'h0, 16'h0000, 4'd8}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic key_vld_i = 1'b0, add_i = 1'b0, sub_i = 1'b0, eq_i = 1'b0, clr_i = 1'b0;
  logic [3:0] key_val_i = '0;
  logic [15:0] disp_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  radix16_calc_ctrl u_radix16_calc_ctrl (
    .clk_i, .rst_ni, .key_vld_i, .key_val_i,
    .add_i, .sub_i, .eq_i, .clr_i, .disp_o
  );

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (disp_o !== exp) begin
      errors++;
      $display("FAIL %s: disp_o=%h expected=%h", req, disp_o, exp);
    end
  endtask

  // drive one cycle of inputs at a falling edge, release at the next
  task automatic drive(input logic kv, input logic [3:0] kval, input logic a,
                       input logic s, input logic e, input logic c);
    @(negedge clk_i);
    key_vld_i = kv; key_val_i = kval; add_i = a; sub_i = s; eq_i = e; clr_i = c;
    @(negedge clk_i);
    key_vld_i = 0; add_i = 0; sub_i = 0; eq_i = 0; clr_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset", 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] k;
      k = VEC[i][26:24];
      drive(k == K_KEY, VEC[i][23:20], k == K_ADD, k == K_SUB, k == K_EQ, k == K_CLR);
      check($sformatf("R%0d step %0d", VEC[i][3:0], i), VEC[i][19:4]);
    end

    // R12: operator beats digit
    drive(1, 4'h5, 1, 0, 0, 0);
    check("R12 add over digit", 16'h0000);
    drive(1, 4'h5, 0, 0, 0, 0);
    check("R12 operand entry reached", 16'h0005);
    // R8: clear from operand entry
    drive(0, 4'h0, 0, 0, 0, 1);
    check("R8 clear in operand entry", 16'h0000);
    drive(1, 4'h3, 0, 0, 0, 0);
    check("R8 back in acc entry", 16'h0003);
    // R12: add beats subtract, clear beats everything
    drive(0, 4'h0, 1, 1, 0, 0);
    check("R12 add+sub", 16'h0000);
    drive(1, 4'h4, 0, 0, 0, 0);
    drive(0, 4'h0, 0, 0, 1, 0);
    check("R12 add chosen", 16'h0007);
    drive(1, 4'h9, 1, 1, 1, 1);
    check("R12 clear wins", 16'h0000);
    drive(1, 4'h1, 0, 0, 0, 0);
    check("R12 acc entry after clear", 16'h0001);
    // R12: equals beats digit in operand entry
    drive(0, 4'h0, 0, 1, 0, 0);
    drive(1, 4'h2, 0, 0, 0, 0);
    drive(1, 4'h8, 0, 0, 1, 0);
    check("R12 equals over digit", 16'hFFFF);
    // R1: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid-run reset", 16'h0000);
    rst_ni = 1'b1;
    drive(1, 4'hC, 0, 0, 0, 0);
    check("R1 acc entry after reset", 16'h000C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule